// File: doc/BRIEF.md
# Three-Share Masked 8-bit Substitution Box

This block evaluates a fixed 8-bit substitution function on data that is split into three Boolean shares. The true byte is the XOR of the three input shares. The result leaves the block as three output shares whose XOR is the substituted byte. No combinational path ever combines all three shares of a bit. Every nonlinear product is built with a threshold-style shared AND: output share s is formed only from the two other shares of its operands.

The function is a three-round Feistel network on two nibbles. The low nibble is bits 3:0 and the high nibble is bits 7:4. Every quadratic stage ends at a register, which stops glitches from spreading across shares. Nibbles that are idle in a given stage are carried through delay registers so that they stay aligned with the stage outputs.

The pipeline has seven register stages. It accepts one byte on every clock and has no back-pressure. Fresh randomness is not generated here, and the shares are not recombined here.

Top module: `tm_sbox_top`

## Requirements
- R1: A synchronous active-high `rst` clears all pipeline registers. In the cycle after a clock edge that samples `rst` high, `out_valid` is 0 and all three output shares are 0x00.
- R2: `out_valid` equals `in_valid` delayed by exactly 7 clock edges. A new byte may be presented on every cycle. Results come out in input order, and gaps in `in_valid` are reproduced unchanged.
- R3: For every input byte x = `in_a`^`in_b`^`in_c`, the output XOR `out_a`^`out_b`^`out_c` equals S(x). S(x) is defined from the nibbles L = x[3:0] and R = x[7:4] by the steps below.
  - Step 1: R ^= F(G(L)).
  - Step 2: L ^= Q(P(Q(R))).
  - Step 3: R ^= F(G'(L)).
  - The result is S(x) = {R, L}.
  - The functions are defined on a nibble n, with n0 as its lowest bit:
  - G sets n0 ^= n1&n2. G' does the same and also inverts n0.
  - F forms a = n1^n3, t = n0^n2, b = a^n2, c = n3^t. It returns {a&t, n0&n3, t, c&b}, written with bit 3 first.
  - Q forms t = (n0&n3)^n1. It returns {n2^(n0&n1), n0, t, n3}, written with bit 3 first.
  - P maps y to {y1, y2, y0, y3}, written with bit 3 first.
- R4: The output XOR depends only on x and not on how x is split. Two presentations of the same x with any masks give the same output XOR. This includes all-zero masks and all-ones masks.
- R5: S is a permutation. The 256 distinct inputs produce 256 distinct output values.
- R6: A reset asserted in the middle of a stream discards every byte in flight. No result for those bytes appears after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_a | input | 8 | Input share A |
| in_b | input | 8 | Input share B |
| in_c | input | 8 | Input share C |
| out_valid | output | 1 | Result strobe, 7 cycles after in_valid |
| out_a | output | 8 | Output share A |
| out_b | output | 8 | Output share B |
| out_c | output | 8 | Output share C |

## Verification
A wrong gate or a misaligned delay register inside a round shows up exactly seven cycles after the affected byte enters. It appears as an output XOR that differs from S(x), and only for the inputs that exercise that path. For this reason all 256 values are streamed back to back. A delay stage that mixes bytes from two different cycles shows up as a dependence on the mask or on the neighbouring byte. The same byte under several masks, and a constant input held across cycles, expose this. A fault in the valid pipeline shows up as a shift or a hole in the output strobe pattern, one cycle early or late.

// File: rtl/tm_sbox_pkg.sv
package tm_sbox_pkg;
    localparam int SHARES = 3;
    localparam int NIB    = 4;
    localparam int BYTE_W = 2 * NIB;
    localparam int DEPTH  = 7;

    typedef logic [SHARES-1:0]          tri_t;   // one bit across shares
    typedef logic [SHARES-1:0][NIB-1:0] nib3_t;  // [share][bit]

    // Shared AND: share s of the product uses only the other two shares.
    function automatic tri_t sh_and(tri_t x, tri_t y);
        tri_t r;
        for (int s = 0; s < SHARES; s++) begin
            int p;
            int q;
            p = (s + 1) % SHARES;
            q = (s + 2) % SHARES;
            r[s] = (x[p] & y[p]) ^ (x[p] & y[q]) ^ (x[q] & y[p]);
        end
        return r;
    endfunction

    function automatic tri_t pick(nib3_t v, int i);
        tri_t r;
        for (int s = 0; s < SHARES; s++) r[s] = v[s][i];
        return r;
    endfunction
endpackage

// File: rtl/tm_sbox_g.sv
module tm_sbox_g
    import tm_sbox_pkg::*;
#(
    parameter bit INVERT = 1'b0
) (
    input  nib3_t x,
    output nib3_t y
);
    tri_t prod;
    assign prod = sh_and(pick(x, 1), pick(x, 2));

    for (genvar s = 0; s < SHARES; s++) begin : g_share
        localparam bit FLIP = (s == 0) && INVERT;
        assign y[s] = {x[s][3:1], x[s][0] ^ prod[s] ^ FLIP};
    end
endmodule

// File: rtl/tm_sbox_f.sv
module tm_sbox_f
    import tm_sbox_pkg::*;
(
    input  nib3_t x,
    output nib3_t y
);
    tri_t x0, x3, a, t, b, c;
    tri_t u0, u1, u3;

    for (genvar s = 0; s < SHARES; s++) begin : g_lin
        assign x0[s] = x[s][0];
        assign x3[s] = x[s][3];
        assign a[s]  = x[s][1] ^ x[s][3];
        assign t[s]  = x[s][0] ^ x[s][2];
        assign b[s]  = a[s] ^ x[s][2];
        assign c[s]  = x[s][3] ^ t[s];
    end

    assign u0 = sh_and(x0, x3);
    assign u3 = sh_and(c, b);
    assign u1 = sh_and(a, t);

    for (genvar s = 0; s < SHARES; s++) begin : g_out
        assign y[s] = {u1[s], u0[s], t[s], u3[s]};
    end
endmodule

// File: rtl/tm_sbox_q.sv
module tm_sbox_q
    import tm_sbox_pkg::*;
(
    input  nib3_t x,
    output nib3_t y
);
    tri_t p03, p01;
    assign p03 = sh_and(pick(x, 0), pick(x, 3));
    assign p01 = sh_and(pick(x, 0), pick(x, 1));

    for (genvar s = 0; s < SHARES; s++) begin : g_share
        assign y[s] = {x[s][2] ^ p01[s], x[s][0], p03[s] ^ x[s][1], x[s][3]};
    end
endmodule

// File: rtl/tm_sbox_top.sv
module tm_sbox_top
    import tm_sbox_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_a,
    input  logic [BYTE_W-1:0] in_b,
    input  logic [BYTE_W-1:0] in_c,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_a,
    output logic [BYTE_W-1:0] out_b,
    output logic [BYTE_W-1:0] out_c
);
    nib3_t lft_in, rgt_in;
    assign lft_in = {in_c[NIB-1:0],      in_b[NIB-1:0],      in_a[NIB-1:0]};
    assign rgt_in = {in_c[BYTE_W-1:NIB], in_b[BYTE_W-1:NIB], in_a[BYTE_W-1:NIB]};

    // Pipeline registers: function output plus delayed halves per stage
    nib3_t st1_g, st1_l, st1_r;
    nib3_t st2_f, st2_l, st2_r;
    nib3_t st3_q, st3_l, st3_r;
    nib3_t st4_q, st4_l, st4_r;
    nib3_t st5_g, st5_l, st5_r;
    nib3_t st6_f, st6_l, st6_r;
    nib3_t st7_l, st7_r;
    logic [DEPTH-1:0] vpipe;

    // Round functions between register stages
    nib3_t g1_y, f1_y, q1_x, q1_y, q2_x, q2_y, lft_mix, g2_y, f2_y;

    tm_sbox_g #(.INVERT(1'b0)) u_g1 (.x(lft_in), .y(g1_y));
    tm_sbox_f                  u_f1 (.x(st1_g),  .y(f1_y));

    assign q1_x = st2_r ^ st2_f;               // first Feistel xor
    tm_sbox_q u_q1 (.x(q1_x), .y(q1_y));

    for (genvar s = 0; s < SHARES; s++) begin : g_perm
        assign q2_x[s] = {st3_q[s][1], st3_q[s][2], st3_q[s][0], st3_q[s][3]};
    end
    tm_sbox_q u_q2 (.x(q2_x), .y(q2_y));

    assign lft_mix = st4_l ^ st4_q;            // second Feistel xor
    tm_sbox_g #(.INVERT(1'b1)) u_g2 (.x(lft_mix), .y(g2_y));
    tm_sbox_f                  u_f2 (.x(st5_g),   .y(f2_y));

    always_ff @(posedge clk) begin
        if (rst) begin
            st1_g <= '0; st1_l <= '0; st1_r <= '0;
            st2_f <= '0; st2_l <= '0; st2_r <= '0;
            st3_q <= '0; st3_l <= '0; st3_r <= '0;
            st4_q <= '0; st4_l <= '0; st4_r <= '0;
            st5_g <= '0; st5_l <= '0; st5_r <= '0;
            st6_f <= '0; st6_l <= '0; st6_r <= '0;
            st7_l <= '0; st7_r <= '0;
            vpipe <= '0;
        end else begin
            st1_g <= g1_y;  st1_l <= lft_in;  st1_r <= rgt_in;
            st2_f <= f1_y;  st2_l <= st1_l;   st2_r <= st1_r;
            st3_q <= q1_y;  st3_l <= st2_l;   st3_r <= q1_x;
            st4_q <= q2_y;  st4_l <= st3_l;   st4_r <= st3_r;
            st5_g <= g2_y;  st5_l <= lft_mix; st5_r <= st4_r;
            st6_f <= f2_y;  st6_l <= st5_l;   st6_r <= st5_r;
            st7_l <= st6_l; st7_r <= st6_r ^ st6_f;   // third Feistel xor
            vpipe <= {vpipe[DEPTH-2:0], in_valid};
        end
    end

    assign out_valid = vpipe[DEPTH-1];
    assign out_a = {st7_r[0], st7_l[0]};
    assign out_b = {st7_r[1], st7_l[1]};
    assign out_c = {st7_r[2], st7_l[2]};
endmodule

// File: rtl/tm_sbox_chk.sv
module tm_sbox_chk
    import tm_sbox_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [BYTE_W-1:0] in_a,
    input logic [BYTE_W-1:0] in_b,
    input logic [BYTE_W-1:0] in_c,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_a,
    input logic [BYTE_W-1:0] out_b,
    input logic [BYTE_W-1:0] out_c
);
    logic [BYTE_W-1:0] in_x, out_x;
    logic [3:0]        live;

    assign in_x  = in_a ^ in_b ^ in_c;
    assign out_x = out_a ^ out_b ^ out_c;

    always_ff @(posedge clk) begin
        if (rst)            live <= '0;
        else if (live != 4'd15) live <= live + 4'd1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_a == '0 && out_b == '0 && out_c == '0));

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (live >= 4'd7) |-> (out_valid == $past(in_valid, 7)));

    assert_mask_indep_R4: assert property (@(posedge clk) disable iff (rst)
        (live >= 4'd8 && $past(in_x, 7) == $past(in_x, 8)) |-> (out_x == $past(out_x)));

    assert_distinct_R5: assert property (@(posedge clk) disable iff (rst)
        (live >= 4'd8 && $past(in_x, 7) != $past(in_x, 8)) |-> (out_x != $past(out_x)));
endmodule

bind tm_sbox_top tm_sbox_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .out_c(out_c)
);

// File: tb/tm_sbox_top_tb_top.sv
module tm_sbox_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_a = '0, in_b = '0, in_c = '0;
    logic       out_valid;
    logic [7:0] out_a, out_b, out_c;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    logic [7:0]  exp_q[$];
    logic [7:0]  got_log[$];
    string       cur_req = "R3";

    always #10 clk = ~clk;   // 50 MHz

    tm_sbox_top dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .out_valid(out_valid), .out_a(out_a), .out_b(out_b), .out_c(out_c)
    );

    // Behavioural unmasked model from the requirement text
    function automatic logic [3:0] m_g(logic [3:0] n, bit inv);
        return {n[3:1], n[0] ^ (n[1] & n[2]) ^ inv};
    endfunction
    function automatic logic [3:0] m_f(logic [3:0] n);
        logic a, t, b, c;
        a = n[1] ^ n[3]; t = n[0] ^ n[2]; b = a ^ n[2]; c = n[3] ^ t;
        return {a & t, n[0] & n[3], t, c & b};
    endfunction
    function automatic logic [3:0] m_q(logic [3:0] n);
        return {n[2] ^ (n[0] & n[1]), n[0], (n[0] & n[3]) ^ n[1], n[3]};
    endfunction
    function automatic logic [7:0] sbox_ref(logic [7:0] x);
        logic [3:0] l, r, y;
        l = x[3:0]; r = x[7:4];
        r = r ^ m_f(m_g(l, 1'b0));
        y = m_q(r);
        l = l ^ m_q({y[1], y[2], y[0], y[3]});
        r = r ^ m_f(m_g(l, 1'b1));
        return {r, l};
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Output monitor: compares every result against the expected queue
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            logic [7:0] got;
            got = out_a ^ out_b ^ out_c;
            got_log.push_back(got);
            if (exp_q.size() == 0) chk(1'b0, "R2 unexpected out_valid", got, 0);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(got == e, cur_req, got, e);
            end
        end
    end

    task automatic drive(logic [7:0] x, logic [7:0] m1, logic [7:0] m2, bit v);
        @(negedge clk);
        in_a = x ^ m1 ^ m2; in_b = m1; in_c = m2; in_valid = v;
        if (v) exp_q.push_back(sbox_ref(x));
    endtask

    task automatic drain();
        @(negedge clk); in_valid = 1'b0;
        repeat (9) @(negedge clk);
        chk(exp_q.size() == 0, "R2 results missing", exp_q.size(), 0);
    endtask

    task automatic test_reset();
        rst = 1'b1; in_valid = 1'b1; in_a = 8'hA5; in_b = 8'h3C; in_c = 8'hF0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk((out_a | out_b | out_c) == 8'h00, "R1 shares", out_a | out_b | out_c, 0);
        in_valid = 1'b0;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic test_all_inputs();
        bit seen [256];
        int dup = 0;
        cur_req = "R3"; got_log.delete();
        for (int x = 0; x < 256; x++) drive(x[7:0], 8'($urandom), 8'($urandom), 1'b1);
        drain();
        chk(got_log.size() == 256, "R3 result count", got_log.size(), 256);
        foreach (got_log[i]) begin
            if (seen[got_log[i]]) dup++;
            seen[got_log[i]] = 1'b1;
        end
        chk(dup == 0, "R5 duplicate outputs", dup, 0);
    endtask

    task automatic test_masks();
        logic [7:0] xs [3] = '{8'h00, 8'h9E, 8'hFF};
        cur_req = "R4";
        foreach (xs[k]) begin
            got_log.delete();
            drive(xs[k], 8'h00, 8'h00, 1'b1);
            drive(xs[k], 8'hFF, 8'hFF, 1'b1);
            drive(xs[k], 8'h5A, 8'hC3, 1'b1);
            drive(xs[k], 8'($urandom), 8'($urandom), 1'b1);
            drain();
            for (int i = 1; i < got_log.size(); i++)
                chk(got_log[i] == got_log[0], "R4 mask dependence", got_log[i], got_log[0]);
        end
    endtask

    task automatic test_latency_gaps();
        cur_req = "R2";
        drive(8'h5A, 8'h11, 8'h22, 1'b1);
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            chk(out_valid == (k == 7), "R2 latency", out_valid, k == 7);
        end
        drain();
        got_log.delete();
        drive(8'h01, 8'h80, 8'h40, 1'b1);
        drive(8'h02, 8'h00, 8'h00, 1'b0);
        drive(8'h03, 8'h7F, 8'h31, 1'b1);
        drive(8'h04, 8'h00, 8'h00, 1'b0);
        drive(8'h05, 8'hE2, 8'h19, 1'b1);
        drain();
        chk(got_log.size() == 3, "R2 gap count", got_log.size(), 3);
    endtask

    task automatic test_mid_reset();
        cur_req = "R6";
        drive(8'h10, 8'h33, 8'h44, 1'b1);
        drive(8'h20, 8'h55, 8'h66, 1'b1);
        drive(8'h30, 8'h77, 8'h88, 1'b1);
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 mid-stream reset", out_valid, 0);
        exp_q.delete(); got_log.delete();
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk(got_log.size() == 0, "R6 flushed bytes emerged", got_log.size(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_latency_gaps();
        test_all_inputs();
        test_masks();
        test_mid_reset();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule